// File: doc/BRIEF.md
# Interrupt Acknowledge and Vector Unit

This unit arbitrates the interrupt sources of a two-channel serial peripheral and handles their acknowledgement. Each channel has three sources: receive, transmit and external status. Every source has an in-service latch. The unit compares the pending sources with the latches to drive an active-low interrupt request. It also drives a daisy-chain enable output, which tells lower-priority devices on the chain whether they may request service.

There are two kinds of acknowledge. A hardware strobe is accepted only while the incoming chain enable is high. A software acknowledge is a read of the vector register while the software-acknowledge mode bit is set. Both kinds latch the highest-priority eligible source as in service. The service routine then releases that latch with a "clear highest in-service" command.

The vector register can be read through either channel:

- A read through channel A returns the programmed vector unchanged.
- A read through channel B returns the vector with a source code inserted.

On a hardware acknowledge, a vector response is produced. Its form depends on the vector-includes-status and no-vector controls. In software-acknowledge mode, both controls are ignored.

Top module: `intr_ack_vec`

## Requirements
- R1: After reset the following hold: no in-service latch is set, `irq_no` is 1, `vec_vld_o` is 0 and `vec_o` is 0.
- R2: Sources are indexed by bit of `pend_i`, and priority runs from index 0 (highest) to index 5 (lowest):
  - index 0: channel A receive
  - index 1: channel A transmit
  - index 2: channel A status
  - index 3: channel B receive
  - index 4: channel B transmit
  - index 5: channel B status

  A pending source is eligible when its priority is strictly higher than that of every set in-service latch. `irq_no` is 0 exactly when at least one source is eligible.
- R3: A hardware acknowledge is `hw_ack_i` high in a cycle where `chain_en_i` is high. It sets the in-service latch of the highest-priority eligible source. When `hw_ack_i` is high while `chain_en_i` is low, it is ignored entirely: no latch is set and no vector response is given.
- R4: A software acknowledge is `rd_vec_i` high while `sw_ack_mode_i` is 1. It has the same latching effect as a hardware acknowledge, on either channel and whatever the value of `chain_en_i`.
- R5: A `clr_ius_i` pulse clears only the highest-priority in-service latch that is set. Every other latch is left unchanged.
- R6: `chain_en_o` is 1 only when all three of these hold: `chain_en_i` is 1, no in-service latch is set, and no source is eligible.
- R7: A vector read through channel A (`rd_ch_b_i`=0) returns `vec_base_i` unchanged. The value appears on `vec_o`, with `vec_vld_o`=1, in the cycle after the read.
- R8: A vector read through channel B (`rd_ch_b_i`=1) returns `vec_base_i` with bits [3:1] replaced by a source code. The code is the index (0 to 5) of the highest-priority eligible source, or 7 when no source is eligible. Timing is the same as in R7.
- R9: With `sw_ack_mode_i`=0, an accepted hardware acknowledge gives a one-cycle response on the next cycle:
  - `nv_i`=1: no response (`vec_vld_o` stays 0).
  - `nv_i`=0 and `vis_i`=0: `vec_o` is the unmodified vector, with `vec_vld_o`=1.
  - `nv_i`=0 and `vis_i`=1: `vec_o` is the code-modified vector of R8, with `vec_vld_o`=1.
- R10: With `sw_ack_mode_i`=1, `vis_i` and `nv_i` are ignored. An accepted hardware acknowledge always returns the unmodified vector with `vec_vld_o`=1.
- R11: An acknowledge made while no source is eligible sets no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 6 | Pending flags per source, bit 0 highest priority |
| chain_en_i | input | 1 | Daisy-chain enable from the higher-priority neighbour |
| hw_ack_i | input | 1 | Hardware acknowledge strobe |
| rd_vec_i | input | 1 | Vector register read strobe |
| rd_ch_b_i | input | 1 | Read is through channel B (1) or channel A (0) |
| sw_ack_mode_i | input | 1 | Software-acknowledge mode bit |
| vis_i | input | 1 | Vector-includes-status control |
| nv_i | input | 1 | No-vector control |
| clr_ius_i | input | 1 | Clear highest in-service latch command |
| vec_base_i | input | 8 | Programmed interrupt vector |
| irq_no | output | 1 | Interrupt request, active low |
| chain_en_o | output | 1 | Daisy-chain enable to lower-priority devices |
| vec_o | output | 8 | Vector read or acknowledge response |
| vec_vld_o | output | 1 | `vec_o` carries a response this cycle |

## Verification
The bench builds the unit with its default parameters: two channels of three sources each, an 8-bit vector, and a 3-bit code field at bits 3:1. With these values, every source index code and the no-eligible code 7 can be observed on the channel B read.

The bench uses this code field to reveal the latch state through the ports. It does so across these sequences:

- nested acknowledges
- clears that peel off one latch at a time
- acknowledges with nothing eligible
- acknowledges blocked by a low chain input

It also covers every combination of software mode with the status and no-vector controls.

// File: rtl/intr_ack_vec_pkg.sv
`timescale 1ns/1ps
package intr_ack_vec_pkg;
  // kind of vector response produced in a cycle
  typedef enum logic [1:0] {
    RESP_NONE = 2'd0,
    RESP_RAW  = 2'd1,
    RESP_MOD  = 2'd2
  } resp_e;
endpackage

// File: rtl/iav_prio.sv
`timescale 1ns/1ps
// fixed priority pick, bit 0 wins
module iav_prio #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] oh_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign oh_o[i]     = req_i[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req_i[i];
  end
  assign any_o = seen[N];
endmodule

// File: rtl/iav_enc.sv
`timescale 1ns/1ps
module iav_enc #(
  parameter int unsigned N = 6,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] oh_i,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (oh_i[i]) idx_o |= W'(i);
    end
  end
endmodule

// File: rtl/iav_ius.sv
`timescale 1ns/1ps
module iav_ius #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  input  logic         ack_i,
  input  logic         clr_i,
  output logic [N-1:0] ius_o,
  output logic [N-1:0] sel_oh_o,
  output logic         sel_any_o
);
  logic [N-1:0] ius_q, elig, clr_oh, set_mask, clr_mask;
  logic [N:0]   cov;
  logic         clr_any;

  // a source is blocked by any latch at its own or higher priority
  assign cov[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_cov
    assign cov[i + 1] = cov[i] | ius_q[i];
    assign elig[i]    = pend_i[i] & ~cov[i + 1];
  end

  iav_prio #(.N(N)) u_sel (.req_i(elig),  .oh_o(sel_oh_o), .any_o(sel_any_o));
  iav_prio #(.N(N)) u_clr (.req_i(ius_q), .oh_o(clr_oh),   .any_o(clr_any));

  assign set_mask = ack_i ? sel_oh_o : '0;
  assign clr_mask = (clr_i && clr_any) ? clr_oh : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ius_q <= '0;
    else         ius_q <= (ius_q & ~clr_mask) | set_mask;
  end

  assign ius_o = ius_q;
endmodule

// File: rtl/iav_vec.sv
`timescale 1ns/1ps
module iav_vec
  import intr_ack_vec_pkg::*;
#(
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned CODE_LSB = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VEC_W-1:0]  base_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rd_i,
  input  logic              rd_b_i,
  input  logic              hw_i,
  input  logic              sw_mode_i,
  input  logic              vis_i,
  input  logic              nv_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vld_o
);
  logic [VEC_W-1:0] mod_vec, vec_q;
  logic             vld_q;
  resp_e            resp;

  always_comb begin
    mod_vec = base_i;
    mod_vec[CODE_LSB +: CODE_W] = code_i;
  end

  // a read wins over a same-cycle hardware response
  always_comb begin
    resp = RESP_NONE;
    if (rd_i)           resp = rd_b_i ? RESP_MOD : RESP_RAW;
    else if (hw_i) begin
      if (sw_mode_i)    resp = RESP_RAW;
      else if (!nv_i)   resp = vis_i ? RESP_MOD : RESP_RAW;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= (resp != RESP_NONE);
      case (resp)
        RESP_RAW: vec_q <= base_i;
        RESP_MOD: vec_q <= mod_vec;
        default:  vec_q <= vec_q;
      endcase
    end
  end

  assign vec_o = vec_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/intr_ack_vec.sv
`timescale 1ns/1ps
module intr_ack_vec #(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned SRC_PER_CH = 3,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned CODE_LSB   = 1,
  localparam int unsigned NUM_SRC   = NUM_CH * SRC_PER_CH,
  localparam int unsigned CODE_W    = $clog2(NUM_SRC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               chain_en_i,
  input  logic               hw_ack_i,
  input  logic               rd_vec_i,
  input  logic               rd_ch_b_i,
  input  logic               sw_ack_mode_i,
  input  logic               vis_i,
  input  logic               nv_i,
  input  logic               clr_ius_i,
  input  logic [VEC_W-1:0]   vec_base_i,
  output logic               irq_no,
  output logic               chain_en_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_vld_o
);
  localparam logic [CODE_W-1:0] CODE_NONE = '1;

  logic [NUM_SRC-1:0] ius, sel_oh;
  logic               sel_any, hw_ok, sw_ack, ack;
  logic [CODE_W-1:0]  sel_idx, code;

  assign hw_ok  = hw_ack_i & chain_en_i;
  assign sw_ack = rd_vec_i & sw_ack_mode_i;
  assign ack    = hw_ok | sw_ack;

  iav_ius #(.N(NUM_SRC)) u_ius (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend_i),
    .ack_i    (ack),
    .clr_i    (clr_ius_i),
    .ius_o    (ius),
    .sel_oh_o (sel_oh),
    .sel_any_o(sel_any)
  );

  iav_enc #(.N(NUM_SRC), .W(CODE_W)) u_enc (.oh_i(sel_oh), .idx_o(sel_idx));

  assign code = sel_any ? sel_idx : CODE_NONE;

  iav_vec #(.VEC_W(VEC_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB)) u_vec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .base_i   (vec_base_i),
    .code_i   (code),
    .rd_i     (rd_vec_i),
    .rd_b_i   (rd_ch_b_i),
    .hw_i     (hw_ok),
    .sw_mode_i(sw_ack_mode_i),
    .vis_i    (vis_i),
    .nv_i     (nv_i),
    .vec_o    (vec_o),
    .vld_o    (vec_vld_o)
  );

  assign irq_no     = ~sel_any;
  assign chain_en_o = chain_en_i & ~(|ius) & ~sel_any;
endmodule

// File: rtl/intr_ack_vec_chk.sv
`timescale 1ns/1ps
module intr_ack_vec_chk #(
  parameter int unsigned N = 6,
  parameter int unsigned VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chain_en_i,
  input logic             chain_en_o,
  input logic             irq_no,
  input logic [N-1:0]     ius,
  input logic             sel_any,
  input logic             ack,
  input logic             clr_ius_i,
  input logic             rd_vec_i,
  input logic             rd_ch_b_i,
  input logic [VEC_W-1:0] vec_base_i,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_vld_o
);
  // R6
  chain_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain_en_i |-> !chain_en_o);
  // R6
  chain_ius_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ius) |-> !chain_en_o);
  // R2
  irq_blocks_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> !chain_en_o);
  // R5
  clr_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ius_i && !ack && (|ius)) |=> $countones(ius) == $countones($past(ius)) - 1);
  // R3
  ack_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && sel_any && !clr_ius_i) |=> $countones(ius) == $countones($past(ius)) + 1);
  // R11
  ack_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !sel_any && !clr_ius_i) |=> ius == $past(ius));
  // R7
  rd_a_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec_i && !rd_ch_b_i) |=> (vec_vld_o && vec_o == $past(vec_base_i)));
endmodule

bind intr_ack_vec intr_ack_vec_chk #(.N(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chain_en_i(chain_en_i),
  .chain_en_o(chain_en_o),
  .irq_no    (irq_no),
  .ius       (ius),
  .sel_any   (sel_any),
  .ack       (ack),
  .clr_ius_i (clr_ius_i),
  .rd_vec_i  (rd_vec_i),
  .rd_ch_b_i (rd_ch_b_i),
  .vec_base_i(vec_base_i),
  .vec_o     (vec_o),
  .vec_vld_o (vec_vld_o)
);

// File: tb/intr_ack_vec_test.sv
`timescale 1ns/1ps
module intr_ack_vec_test;
  localparam int BASE = 'hA5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] pend_i = '0;
  logic       chain_en_i = 1'b1, hw_ack_i = 1'b0, rd_vec_i = 1'b0, rd_ch_b_i = 1'b0;
  logic       sw_ack_mode_i = 1'b0, vis_i = 1'b0, nv_i = 1'b0, clr_ius_i = 1'b0;
  logic [7:0] vec_base_i = 8'hA5;
  logic       irq_no, chain_en_o, vec_vld_o;
  logic [7:0] vec_o;
  int         n_tests = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  intr_ack_vec uut (
    .clk_i(clk), .rst_ni(rst_ni), .pend_i(pend_i), .chain_en_i(chain_en_i),
    .hw_ack_i(hw_ack_i), .rd_vec_i(rd_vec_i), .rd_ch_b_i(rd_ch_b_i),
    .sw_ack_mode_i(sw_ack_mode_i), .vis_i(vis_i), .nv_i(nv_i),
    .clr_ius_i(clr_ius_i), .vec_base_i(vec_base_i), .irq_no(irq_no),
    .chain_en_o(chain_en_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o)
  );

  function automatic int modv(int c);
    return (BASE & 'hF1) | (c << 1);
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; pend_i = '0; chain_en_i = 1'b1; hw_ack_i = 1'b0; rd_vec_i = 1'b0;
    rd_ch_b_i = 1'b0; sw_ack_mode_i = 1'b0; vis_i = 1'b0; nv_i = 1'b0; clr_ius_i = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic hwack();
    hw_ack_i = 1'b1; @(negedge clk); hw_ack_i = 1'b0; #1;
  endtask

  task automatic rd(input bit ch_b);
    rd_vec_i = 1'b1; rd_ch_b_i = ch_b; @(negedge clk); rd_vec_i = 1'b0; #1;
  endtask

  task automatic clr();
    clr_ius_i = 1'b1; @(negedge clk); clr_ius_i = 1'b0; #1;
  endtask

  task automatic t_reset();
    do_reset(); #1;
    chk("R1 irq_no", 32'(irq_no), 1);
    chk("R1 vec_vld_o", 32'(vec_vld_o), 0);
    chk("R1 vec_o", 32'(vec_o), 0);
    chk("R6 chain_en_o idle", 32'(chain_en_o), 1);
  endtask

  task automatic t_prio();
    do_reset();
    pend_i = 6'b101000; #1;
    chk("R2 irq_no pending", 32'(irq_no), 0);
    chk("R6 chain_en_o pending", 32'(chain_en_o), 0);
    rd(1'b1);
    chk("R8 vld", 32'(vec_vld_o), 1);
    chk("R8 code 3", 32'(vec_o), 32'(modv(3)));
    chk("R2 read not ack", 32'(irq_no), 0);
    pend_i = '0; rd(1'b1);
    chk("R8 code none", 32'(vec_o), 32'(modv(7)));
    chain_en_i = 1'b0; #1;
    chk("R6 chain_en_i low", 32'(chain_en_o), 0);
  endtask

  task automatic t_hw_nest();
    do_reset();
    vis_i = 1'b1; pend_i = 6'b001010;
    hwack();
    chk("R9 vis vld", 32'(vec_vld_o), 1);
    chk("R9 vis code 1", 32'(vec_o), 32'(modv(1)));
    chk("R3 latched irq released", 32'(irq_no), 1);
    chk("R6 chain low in service", 32'(chain_en_o), 0);
    pend_i = 6'b001011; #1;
    chk("R2 higher prio requests", 32'(irq_no), 0);
    hwack();
    chk("R3 nested code 0", 32'(vec_o), 32'(modv(0)));
    chk("R3 nested released", 32'(irq_no), 1);
    clr();
    chk("R5 top latch cleared", 32'(irq_no), 0);
    pend_i = 6'b001010; #1;
    chk("R5 lower latch kept", 32'(irq_no), 1);
    clr();
    chk("R5 second clear", 32'(irq_no), 0);
    rd(1'b1);
    chk("R5 code after clears", 32'(vec_o), 32'(modv(1)));
  endtask

  task automatic t_hw_opts();
    do_reset();
    pend_i = 6'b010000; vis_i = 1'b0; nv_i = 1'b0;
    hwack();
    chk("R9 raw vld", 32'(vec_vld_o), 1);
    chk("R9 raw vec", 32'(vec_o), 32'(BASE));
    do_reset();
    pend_i = 6'b010000; vis_i = 1'b1; nv_i = 1'b1;
    hwack();
    chk("R9 nv no response", 32'(vec_vld_o), 0);
    chk("R9 nv still latches", 32'(irq_no), 1);
  endtask

  task automatic t_chain_gate();
    do_reset();
    pend_i = 6'b010000; vis_i = 1'b1; chain_en_i = 1'b0;
    hwack();
    chk("R3 gated no response", 32'(vec_vld_o), 0);
    chain_en_i = 1'b1; #1;
    chk("R3 gated no latch irq", 32'(irq_no), 0);
    rd(1'b1);
    chk("R3 gated code 4", 32'(vec_o), 32'(modv(4)));
  endtask

  task automatic t_sw_ack();
    do_reset();
    sw_ack_mode_i = 1'b1; chain_en_i = 1'b0; vis_i = 1'b1; nv_i = 1'b1;
    pend_i = 6'b000100;
    rd(1'b0);
    chk("R7 raw vld", 32'(vec_vld_o), 1);
    chk("R7 raw vec", 32'(vec_o), 32'(BASE));
    chk("R4 sw ack latches", 32'(irq_no), 1);
    pend_i = 6'b000101; #1;
    chk("R4 higher pending", 32'(irq_no), 0);
    rd(1'b1);
    chk("R4 chan B sw ack code 0", 32'(vec_o), 32'(modv(0)));
    chk("R4 chan B sw ack latches", 32'(irq_no), 1);
  endtask

  task automatic t_sw_hw();
    do_reset();
    sw_ack_mode_i = 1'b1; vis_i = 1'b1; nv_i = 1'b1; pend_i = 6'b100000;
    hwack();
    chk("R10 vld despite nv", 32'(vec_vld_o), 1);
    chk("R10 raw despite vis", 32'(vec_o), 32'(BASE));
    chk("R10 latched", 32'(irq_no), 1);
  endtask

  task automatic t_no_elig();
    do_reset();
    vis_i = 1'b1;
    hwack();
    chk("R11 empty ack code", 32'(vec_o), 32'(modv(7)));
    pend_i = 6'b001000; #1;
    chk("R11 empty ack no latch", 32'(irq_no), 0);
    rd(1'b1);
    chk("R11 code 3 after empty ack", 32'(vec_o), 32'(modv(3)));
    pend_i = 6'b000010;
    hwack();
    pend_i = 6'b010000; #1;
    chk("R2 lower blocked", 32'(irq_no), 1);
    hwack();
    clr();
    chk("R11 blocked ack no latch", 32'(irq_no), 0);
  endtask

  initial begin
    t_reset();
    t_prio();
    t_hw_nest();
    t_hw_opts();
    t_chain_gate();
    t_sw_ack();
    t_sw_hw();
    t_no_elig();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule